// File: doc/BRIEF.md
# Macro Sequencer Core

This block is a small 32-bit sequencer that runs command macros stored in an instruction memory. A pulse on `start` clears the eight-entry register file, the method-address state and the carry flag. It loads the start parameter into register 1 and primes the fetch stage from `start_addr`. After that it steps through 32-bit instructions. Each instruction either computes an ALU value and assigns it, or tests a register and branches.

An assignment can also pop a word from the parameter stream, load a method address and increment from a value, or emit an (address, data) method write on the output port. Both streams use a valid/ready handshake. The core waits when it needs a parameter and none is offered, and it waits when it must emit and the sink is not ready.

Fetching goes through a one-word prefetch register, so every branch has a delay slot. A taken branch can squash that slot. An instruction flagged as exit still lets the next instruction run before `done` pulses.

Top module: `mseq_core`

## Requirements
- R1: After reset, and whenever idle, `busy`, `done`, `out_valid`, `param_ready` and `imem_rd` are all low.
- R2: Instruction bits [2:0]=0 is a register ALU operation selected by bits [21:17]. The codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow (subtracts one more when carry is clear), 8 xor, 9 or, 10 and, 11 A and not B, 12 not (A and B). Destination is bits [10:8], A is bits [13:11], B is bits [16:14].
- R3: At start all registers are cleared and register 1 takes `start_param`. Register 0 always reads zero, and writes to it are lost.
- R4: The assignment mode in bits [6:4] chooses what is written. Modes 0, 3 and 5 write a popped parameter and discard the ALU value; the other modes write the ALU value.
- R5: Modes 2, 5, 6 and 7 load the method address from value bits [11:0] and the increment from bits [17:12]. Modes 3, 4, 6 and 7 emit one write at the current method address, after which the address grows by the increment. Mode 6 emits a popped parameter, mode 7 emits value bits [17:12], and modes 3 and 4 emit the ALU value.
- R6: Bits [2:0]=7 is a branch on register A. With bit 4 set it is taken when A is nonzero, otherwise when A is zero. The target is the branch's own byte address plus the sign-extended bits [31:14] times 4. The following instruction (delay slot) runs before the target.
- R7: A taken branch with bit 5 set discards its delay slot.
- R8: An instruction with bit 7 set, unless it is a taken branch, ends the macro after exactly one further instruction. `done` then pulses for one cycle as `busy` falls.
- R9: With no parameter offered, or with `out_ready` low, the core holds the instruction without loss and keeps the pending output stable.
- R10: Operation 1 adds the sign-extended immediate in bits [31:14] to A.
- R11: Operations 2, 3 and 4 are bit-field operations, using source bit bits [21:17], width bits [26:22] and target bit bits [31:27]. Operation 2 inserts B's field into A. Operation 3 extracts from B at shift A and places the field at the target bit. Operation 4 extracts from B at the source bit and shifts it left by A.
- R12: Add and subtract update the carry (carry out, or no-borrow), and add-with-carry consumes it. Operations 5 and 6 give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a macro (accepted when idle) |
| start_addr | input | IADDR_W | Byte address of the first instruction |
| start_param | input | 32 | Value for register 1 |
| busy | output | 1 | Macro running |
| done | output | 1 | One-cycle pulse when the macro ends |
| imem_rd | output | 1 | Instruction read strobe |
| imem_addr | output | IADDR_W | Instruction byte address |
| imem_rdata | input | 32 | Instruction word, one cycle after the strobe |
| param_valid | input | 1 | Parameter word offered |
| param_ready | output | 1 | Parameter word taken |
| param_data | input | 32 | Parameter word |
| out_valid | output | 1 | Method write offered |
| out_ready | input | 1 | Method write accepted |
| out_addr | output | 12 | Method address |
| out_data | output | 32 | Method data |

## Verification
The ALU is tried with a table of operand pairs per operation. Carry-in and wrap-around entries separate add from add-with-carry and subtract from subtract-with-borrow. A method-address macro mixes every address-loading and emitting mode, so that the increment, the mode 7 high bits and the pops of modes 5 and 6 are all distinguishable in the emitted order. Branch loops, run with and without squash, show whether the delay slot runs on each pass through the emitted sequence. Held-back parameter and sink handshakes show that stalls lose nothing.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;
   localparam int WORD_W = 32;
   localparam int MA_W   = 12;
   localparam int INC_W  = 6;
   localparam int NREG   = 8;

   typedef enum logic [2:0] {
      OP_REG   = 3'd0,
      OP_ADDI  = 3'd1,
      OP_BFINS = 3'd2,
      OP_BFXA  = 3'd3,
      OP_BFXB  = 3'd4,
      OP_RSV5  = 3'd5,
      OP_RSV6  = 3'd6,
      OP_BRAN  = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      AM_POP       = 3'd0,
      AM_MOV       = 3'd1,
      AM_MOV_MA    = 3'd2,
      AM_POP_EMIT  = 3'd3,
      AM_MOV_EMIT  = 3'd4,
      AM_POP_MA    = 3'd5,
      AM_MA_EPOP   = 3'd6,
      AM_MA_EHIGH  = 3'd7
   } asg_e;

   localparam logic [4:0] SUB_ADD  = 5'd0;
   localparam logic [4:0] SUB_ADC  = 5'd1;
   localparam logic [4:0] SUB_SUB  = 5'd2;
   localparam logic [4:0] SUB_SBB  = 5'd3;
   localparam logic [4:0] SUB_XOR  = 5'd8;
   localparam logic [4:0] SUB_OR   = 5'd9;
   localparam logic [4:0] SUB_AND  = 5'd10;
   localparam logic [4:0] SUB_ANDN = 5'd11;
   localparam logic [4:0] SUB_NAND = 5'd12;
endpackage

// File: rtl/mseq_alu.sv
`timescale 1ns/1ps
module mseq_alu #(
   parameter int  W            = 32,
   parameter bit  HAS_BITFIELD = 1'b1
) (
   input  logic [2:0]   op,
   input  logic [4:0]   subop,
   input  logic [4:0]   bf_sb,
   input  logic [4:0]   bf_sz,
   input  logic [4:0]   bf_db,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] imm,
   input  logic         carry_in,
   output logic [W-1:0] result,
   output logic         carry_out,
   output logic         carry_we
);
   import mseq_pkg::*;

   logic [W:0]   wide;
   logic [W-1:0] reg_res;
   logic [W-1:0] bf_res;

   always_comb begin
      wide      = '0;
      reg_res   = '0;
      carry_out = 1'b0;
      carry_we  = 1'b0;
      case (subop)
         SUB_ADD: begin
            wide = {1'b0, a} + {1'b0, b};
            reg_res = wide[W-1:0]; carry_out = wide[W]; carry_we = 1'b1;
         end
         SUB_ADC: begin
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, carry_in};
            reg_res = wide[W-1:0]; carry_out = wide[W]; carry_we = 1'b1;
         end
         SUB_SUB: begin
            wide = {1'b0, a} - {1'b0, b};
            reg_res = wide[W-1:0]; carry_out = ~wide[W]; carry_we = 1'b1;
         end
         SUB_SBB: begin
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ~carry_in};
            reg_res = wide[W-1:0]; carry_out = ~wide[W]; carry_we = 1'b1;
         end
         SUB_XOR:  reg_res = a ^ b;
         SUB_OR:   reg_res = a | b;
         SUB_AND:  reg_res = a & b;
         SUB_ANDN: reg_res = a & ~b;
         SUB_NAND: reg_res = ~(a & b);
         default:  reg_res = '0;
      endcase
      if (op != OP_REG) carry_we = 1'b0;
   end

   generate
      if (HAS_BITFIELD) begin : g_bf
         logic [W-1:0] mask;
         always_comb begin
            mask = (W'(1) << bf_sz) - W'(1);
            case (op)
               OP_BFINS: bf_res = (((b >> bf_sb) & mask) << bf_db) | (a & ~(mask << bf_db));
               OP_BFXA:  bf_res = ((b >> a[4:0]) & mask) << bf_db;
               OP_BFXB:  bf_res = ((b >> bf_sb) & mask) << a[4:0];
               default:  bf_res = '0;
            endcase
         end
      end else begin : g_nobf
         assign bf_res = '0;
      end
   endgenerate

   always_comb begin
      case (op)
         OP_REG:                     result = reg_res;
         OP_ADDI:                    result = a + imm;
         OP_BFINS, OP_BFXA, OP_BFXB: result = bf_res;
         default:                    result = '0;
      endcase
   end
endmodule

// File: rtl/mseq_regs.sv
`timescale 1ns/1ps
module mseq_regs #(
   parameter int NREG = 8,
   parameter int W    = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic [W-1:0]            init_r1,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [W-1:0]            wdata,
   input  logic [$clog2(NREG)-1:0] ra,
   input  logic [$clog2(NREG)-1:0] rb,
   output logic [W-1:0]            qa,
   output logic [W-1:0]            qb
);
   localparam int IW = $clog2(NREG);

   logic [W-1:0] q [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         if (i == 0) begin : g_zero
            assign q[i] = '0;
         end else begin : g_flop
            logic [W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                          r <= '0;
               else if (clr)                        r <= (i == 1) ? init_r1 : '0;
               else if (we && waddr == IW'(i))      r <= wdata;
            end
            assign q[i] = r;
         end
      end
   endgenerate

   assign qa = q[ra];
   assign qb = q[rb];
endmodule

// File: rtl/mseq_core.sv
`timescale 1ns/1ps
module mseq_core #(
   parameter int IADDR_W      = 16,
   parameter bit HAS_BITFIELD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [IADDR_W-1:0] start_addr,
   input  logic [31:0]        start_param,
   output logic               busy,
   output logic               done,
   output logic               imem_rd,
   output logic [IADDR_W-1:0] imem_addr,
   input  logic [31:0]        imem_rdata,
   input  logic               param_valid,
   output logic               param_ready,
   input  logic [31:0]        param_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [11:0]        out_addr,
   output logic [31:0]        out_data
);
   import mseq_pkg::*;

   localparam int RIW = $clog2(NREG);
   localparam logic [IADDR_W-1:0] STEP = IADDR_W'(4);

   generate
      if (IADDR_W < 4 || IADDR_W > 32) begin : g_bad_iaddr
         $error("mseq_core: IADDR_W must lie in 4..32");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_LOAD, ST_EXEC} st_e;

   st_e                state;
   logic [IADDR_W-1:0] fetch_pc, pipe_addr, cur_addr;
   logic [31:0]        pipe, opc;
   logic               drop_next, last_pass;
   logic [MA_W-1:0]    maddr;
   logic [INC_W-1:0]   minc;
   logic               carry;

   op_e         op;
   asg_e        asg;
   logic        is_br, br_taken, need_pop, need_emit, load_ma, wr_pop, fire, in_exec;
   logic [31:0] imm32, br_off, ra_val, rb_val, alu_res;
   logic        c_out, c_we;
   logic [MA_W-1:0]  emit_addr;
   logic [INC_W-1:0] emit_inc;
   logic             start_go;

   logic unused_bits;
   assign unused_bits = ^{opc[3], start_addr[1:0]};

   assign op       = op_e'(opc[2:0]);
   assign asg      = asg_e'(opc[6:4]);
   assign is_br    = (op == OP_BRAN);
   assign imm32    = {{14{opc[31]}}, opc[31:14]};
   assign br_off   = {imm32[29:0], 2'b00};
   assign in_exec  = (state == ST_EXEC);
   assign start_go = (state == ST_IDLE) && start;

   assign br_taken  = is_br && (opc[4] ? (ra_val != '0) : (ra_val == '0));
   assign need_pop  = !is_br && (asg inside {AM_POP, AM_POP_EMIT, AM_POP_MA, AM_MA_EPOP});
   assign need_emit = !is_br && (asg inside {AM_POP_EMIT, AM_MOV_EMIT, AM_MA_EPOP, AM_MA_EHIGH});
   assign load_ma   = !is_br && (asg inside {AM_MOV_MA, AM_POP_MA, AM_MA_EPOP, AM_MA_EHIGH});
   assign wr_pop    = asg inside {AM_POP, AM_POP_EMIT, AM_POP_MA};

   assign fire        = in_exec && (!need_pop || param_valid) && (!need_emit || out_ready);
   assign param_ready = in_exec && need_pop && (!need_emit || out_ready);
   assign out_valid   = in_exec && need_emit && (!need_pop || param_valid);

   assign emit_addr = load_ma ? alu_res[MA_W-1:0] : maddr;
   assign emit_inc  = load_ma ? alu_res[MA_W+INC_W-1:MA_W] : minc;
   assign out_addr  = emit_addr;

   always_comb begin
      case (asg)
         AM_MA_EPOP:  out_data = param_data;
         AM_MA_EHIGH: out_data = {{(32-INC_W){1'b0}}, alu_res[MA_W+INC_W-1:MA_W]};
         default:     out_data = alu_res;
      endcase
   end

   assign busy      = (state != ST_IDLE);
   assign imem_rd   = (state == ST_REQ);
   assign imem_addr = fetch_pc;

   mseq_regs #(.NREG(NREG), .W(WORD_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_go),
      .init_r1 (start_param),
      .we      (fire && !is_br),
      .waddr   (opc[8 +: RIW]),
      .wdata   (wr_pop ? param_data : alu_res),
      .ra      (opc[11 +: RIW]),
      .rb      (opc[14 +: RIW]),
      .qa      (ra_val),
      .qb      (rb_val)
   );

   mseq_alu #(.W(WORD_W), .HAS_BITFIELD(HAS_BITFIELD)) u_alu (
      .op        (opc[2:0]),
      .subop     (opc[21:17]),
      .bf_sb     (opc[21:17]),
      .bf_sz     (opc[26:22]),
      .bf_db     (opc[31:27]),
      .a         (ra_val),
      .b         (rb_val),
      .imm       (imm32),
      .carry_in  (carry),
      .result    (alu_res),
      .carry_out (c_out),
      .carry_we  (c_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         fetch_pc  <= '0;
         pipe_addr <= '0;
         cur_addr  <= '0;
         pipe      <= '0;
         opc       <= '0;
         drop_next <= 1'b0;
         last_pass <= 1'b0;
         maddr     <= '0;
         minc      <= '0;
         carry     <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  fetch_pc  <= {start_addr[IADDR_W-1:2], 2'b00};
                  drop_next <= 1'b1;
                  last_pass <= 1'b0;
                  maddr     <= '0;
                  minc      <= '0;
                  carry     <= 1'b0;
                  state     <= ST_REQ;
               end
            end
            ST_REQ: state <= ST_LOAD;
            ST_LOAD: begin
               opc       <= pipe;
               cur_addr  <= pipe_addr;
               pipe      <= imem_rdata;
               pipe_addr <= fetch_pc;
               fetch_pc  <= fetch_pc + STEP;
               if (drop_next) begin
                  drop_next <= 1'b0;
                  state     <= ST_REQ;
               end else begin
                  state <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               if (fire) begin
                  if (c_we) carry <= c_out;
                  if (need_emit)    maddr <= emit_addr + MA_W'(emit_inc);
                  else if (load_ma) maddr <= alu_res[MA_W-1:0];
                  if (load_ma) minc <= emit_inc;
                  if (br_taken) begin
                     fetch_pc  <= cur_addr + br_off[IADDR_W-1:0];
                     drop_next <= opc[5];
                  end
                  if (last_pass) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     if (opc[7] && !br_taken) last_pass <= 1'b1;
                     state <= ST_REQ;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mseq_core_chk.sv
`timescale 1ns/1ps
module mseq_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic        param_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [11:0] out_addr,
   input logic [31:0] out_data
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!out_valid && !param_ready)) else $error("idle core drives a handshake"); // R1

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)))
      else $error("pending method write changed"); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R8

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy) else $error("done while still busy"); // R8

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy) else $error("start not taken"); // R3
endmodule

bind mseq_core mseq_core_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .param_ready (param_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_addr    (out_addr),
   .out_data    (out_data)
);

// File: tb/tb_mseq_core.sv
`timescale 1ns/1ps
module tb_mseq_core;
   localparam int IAW = 16;
   localparam logic [31:0] EX  = 32'h80;
   localparam logic [31:0] NOP = 32'h11;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n, start, out_ready, pgate;
   logic [IAW-1:0]  start_addr;
   logic [31:0]     start_param;
   logic            busy, done, imem_rd, param_ready, out_valid;
   logic [IAW-1:0]  imem_addr;
   logic [31:0]     imem_rdata, param_data, out_data;
   logic [11:0]     out_addr;
   logic            param_valid;

   mseq_core #(.IADDR_W(IAW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .start_param(start_param), .busy(busy), .done(done),
      .imem_rd(imem_rd), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .param_valid(param_valid), .param_ready(param_ready), .param_data(param_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data)
   );

   // instruction memory model
   logic [31:0] mem [32];
   always @(posedge clk) if (imem_rd) imem_rdata <= mem[imem_addr[6:2]];

   // parameter source
   logic [31:0] plist [8];
   int          pcount, pidx;
   logic        src_clr, sink_clr;
   assign param_valid = pgate && (pidx < pcount);
   assign param_data  = plist[pidx[2:0]];
   always @(posedge clk)
      if (src_clr) pidx <= 0;
      else if (param_valid && param_ready) pidx <= pidx + 1;

   // method-write sink
   logic [11:0] e_addr [16];
   logic [31:0] e_data [16];
   int          ecnt;
   always @(posedge clk)
      if (sink_clr) ecnt <= 0;
      else if (out_valid && out_ready) begin
         if (ecnt < 16) begin
            e_addr[ecnt[3:0]] <= out_addr;
            e_data[ecnt[3:0]] <= out_data;
         end
         ecnt <= ecnt + 1;
      end

   // expected emissions
   logic [11:0] x_addr [16];
   logic [31:0] x_data [16];
   int          xn;

   int nchk = 0, nerr = 0;

   // stimulus table: sub-op, A, B, expected
   localparam logic [31:0] VEC [11][4] = '{
      '{32'd0,  32'd5,        32'd7,        32'd12},
      '{32'd0,  32'hFFFFFFFF, 32'd2,        32'd1},
      '{32'd1,  32'd5,        32'd7,        32'd12},
      '{32'd2,  32'd10,       32'd3,        32'd7},
      '{32'd2,  32'd3,        32'd10,       32'hFFFFFFF9},
      '{32'd3,  32'd10,       32'd3,        32'd6},
      '{32'd8,  32'h0000F0F0, 32'h0000FF00, 32'h00000FF0},
      '{32'd9,  32'h0000F0F0, 32'h0000FF00, 32'h0000FFF0},
      '{32'd10, 32'h0000F0F0, 32'h0000FF00, 32'h0000F000},
      '{32'd11, 32'h0000F0F0, 32'h0000FF00, 32'h000000F0},
      '{32'd12, 32'h0000F0F0, 32'h0000FF00, 32'hFFFF0FFF}
   };

   function automatic logic [31:0] i_addi(logic [31:0] mode, dst, a, imm);
      return (imm << 14) | (a << 11) | (dst << 8) | (mode << 4) | 32'd1;
   endfunction
   function automatic logic [31:0] i_reg(logic [31:0] sub, mode, dst, a, b);
      return (sub << 17) | (b << 14) | (a << 11) | (dst << 8) | (mode << 4);
   endfunction
   function automatic logic [31:0] i_bf(logic [31:0] op, mode, dst, a, b, sb, sz, db);
      return (db << 27) | (sz << 22) | (sb << 17) | (b << 14) | (a << 11) | (dst << 8) | (mode << 4) | op;
   endfunction
   function automatic logic [31:0] i_br(logic [31:0] nz, sq, a, imm);
      return (imm << 14) | (a << 11) | (sq << 5) | (nz << 4) | 32'd7;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 32; i++) mem[i] = NOP;
   endtask

   task automatic launch();
      @(negedge clk); sink_clr = 1'b1; src_clr = 1'b1;
      @(negedge clk); sink_clr = 1'b0; src_clr = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 3000) begin @(negedge clk); n++; end
      check(done == 1'b1, req, 32'(done), 32'd1);
   endtask

   task automatic expect_emits(input string req);
      check(ecnt == xn, req, 32'(ecnt), 32'(xn));
      for (int i = 0; i < xn && i < ecnt; i++) begin
         check(e_addr[i] == x_addr[i], req, 32'(e_addr[i]), 32'(x_addr[i]));
         check(e_data[i] == x_data[i], req, e_data[i], x_data[i]);
      end
   endtask

   task automatic alu_prog(input logic [31:0] sub);
      clear_mem();
      mem[0] = i_addi(0, 2, 0, 7);
      mem[1] = i_addi(0, 3, 0, 7);
      mem[2] = i_reg(sub, 4, 4, 2, 3) | EX;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; out_ready = 1'b1; pgate = 1'b1;
      start_addr = '0; start_param = '0; pcount = 0;
      src_clr = 1'b1; sink_clr = 1'b1;
      clear_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      check(!busy && !done && !out_valid && !param_ready && !imem_rd, "R1 reset idle",
            {27'd0, busy, done, out_valid, param_ready, imem_rd}, 32'd0);

      // R2 / R4 / R12: table walk, mode 0 writes the popped word, not the immediate
      for (int v = 0; v < 11; v++) begin
         alu_prog(VEC[v][0]);
         plist[0] = VEC[v][1]; plist[1] = VEC[v][2]; pcount = 2;
         launch(); wait_done("R2 alu vector");
         xn = 1; x_addr[0] = 12'h000; x_data[0] = VEC[v][3];
         expect_emits("R2 R4 alu result");
      end

      // R3: start parameter in r1, r0 reads zero, r3 cleared at entry
      clear_mem();
      mem[0] = i_reg(0, 4, 0, 1, 0);
      mem[1] = i_addi(1, 0, 0, 5);
      mem[2] = i_addi(4, 2, 0, 0) | EX;
      mem[3] = i_reg(0, 4, 0, 2, 3);
      start_param = 32'h13579BDF; pcount = 0;
      launch(); wait_done("R3 entry");
      xn = 3;
      x_addr[0] = 0; x_data[0] = 32'h13579BDF;
      x_addr[1] = 0; x_data[1] = 0;
      x_addr[2] = 0; x_data[2] = 0;
      expect_emits("R3 entry state");

      // R5 / R4: method address modes
      clear_mem();
      mem[0] = i_addi(2, 0, 0, 32'h2100);
      mem[1] = i_addi(4, 0, 0, 7);
      mem[2] = i_addi(4, 0, 0, 9);
      mem[3] = i_addi(7, 0, 0, 32'h3040);
      mem[4] = i_addi(6, 0, 0, 32'h1010);
      mem[5] = i_addi(5, 5, 0, 32'h1020);
      mem[6] = i_reg(0, 4, 0, 5, 0) | EX;
      mem[7] = i_addi(3, 5, 0, 32'h22);
      plist[0] = 32'hCAFE0001; plist[1] = 32'h0BAD0002; plist[2] = 32'h5; pcount = 3;
      launch(); wait_done("R5 maddr run");
      xn = 6;
      x_addr[0] = 12'h100; x_data[0] = 7;
      x_addr[1] = 12'h102; x_data[1] = 9;
      x_addr[2] = 12'h040; x_data[2] = 3;
      x_addr[3] = 12'h010; x_data[3] = 32'hCAFE0001;
      x_addr[4] = 12'h020; x_data[4] = 32'h0BAD0002;
      x_addr[5] = 12'h021; x_data[5] = 32'h22;
      expect_emits("R5 R4 method writes");

      // R6 / R10: loop with delay slot and negative immediates
      clear_mem();
      mem[0] = i_addi(1, 2, 0, 3);
      mem[1] = i_addi(4, 2, 2, 32'hFFFFFFFF);
      mem[2] = i_br(1, 0, 2, 32'hFFFFFFFF);
      mem[3] = i_addi(4, 0, 0, 32'h55);
      mem[4] = i_addi(4, 0, 0, 32'h77) | EX;
      pcount = 0;
      launch(); wait_done("R6 loop");
      xn = 7;
      for (int i = 0; i < 7; i++) x_addr[i] = 0;
      x_data[0] = 2; x_data[1] = 32'h55; x_data[2] = 1; x_data[3] = 32'h55;
      x_data[4] = 0; x_data[5] = 32'h55; x_data[6] = 32'h77;
      expect_emits("R6 R10 delay slot loop");

      // R7: same loop, delay slot squashed on taken passes
      mem[2] = i_br(1, 1, 2, 32'hFFFFFFFF);
      launch(); wait_done("R7 loop");
      xn = 5;
      x_data[0] = 2; x_data[1] = 1; x_data[2] = 0; x_data[3] = 32'h55; x_data[4] = 32'h77;
      expect_emits("R7 squash");

      // R8 / R6: branch on zero with squash, exit runs exactly one more
      clear_mem();
      mem[0] = i_br(0, 1, 0, 3);
      mem[1] = i_addi(4, 0, 0, 32'h11);
      mem[2] = i_addi(4, 0, 0, 32'h22);
      mem[3] = i_addi(4, 0, 0, 32'h33) | EX;
      mem[4] = i_addi(4, 0, 0, 32'h44);
      mem[5] = i_addi(4, 0, 0, 32'h66);
      launch(); wait_done("R8 exit");
      xn = 2; x_addr[0] = 0; x_addr[1] = 0; x_data[0] = 32'h33; x_data[1] = 32'h44;
      expect_emits("R8 R6 exit slot");
      @(negedge clk);
      check(!busy && !done, "R8 idle after done", {30'd0, busy, done}, 32'd0);

      // R11 / R12: carry chain and bit-field operations
      clear_mem();
      mem[0] = i_addi(0, 2, 0, 0);
      mem[1] = i_addi(0, 3, 0, 0);
      mem[2] = i_addi(0, 6, 0, 0);
      mem[3] = i_reg(0, 4, 0, 2, 3);
      mem[4] = i_reg(1, 4, 0, 0, 0);
      mem[5] = i_bf(2, 4, 0, 2, 6, 4, 8, 16);
      mem[6] = i_bf(3, 4, 0, 3, 6, 0, 4, 8);
      mem[7] = i_bf(4, 4, 0, 3, 6, 8, 8, 0) | EX;
      plist[0] = 32'hFFFFFFFF; plist[1] = 32'h1; plist[2] = 32'h0000ABCD; pcount = 3;
      launch(); wait_done("R11 run");
      xn = 5;
      for (int i = 0; i < 5; i++) x_addr[i] = 0;
      x_data[0] = 0; x_data[1] = 1; x_data[2] = 32'hFFBCFFFF;
      x_data[3] = 32'h600; x_data[4] = 32'h156;
      expect_emits("R11 R12 bitfield carry");

      // R9: stall on empty parameter stream and on a busy sink
      alu_prog(0);
      plist[0] = 5; plist[1] = 7; pcount = 2;
      pgate = 1'b0;
      launch();
      repeat (20) @(negedge clk);
      check(busy && param_ready && ecnt == 0, "R9 param stall",
            {30'd0, busy, param_ready}, 32'd3);
      out_ready = 1'b0; pgate = 1'b1;
      repeat (20) @(negedge clk);
      check(out_valid && ecnt == 0, "R9 sink stall valid", 32'(out_valid), 32'd1);
      check(out_data == 32'd12, "R9 sink stall data", out_data, 32'd12);
      out_ready = 1'b1;
      wait_done("R9 resume");
      xn = 1; x_addr[0] = 0; x_data[0] = 12;
      expect_emits("R9 no loss");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule